// File: doc/BRIEF.md
# Floppy DMA bridge register interface

This block sits between a 16-bit host bus and two byte-wide neighbours: a floppy disk controller and a memory port. The host reaches everything through a handful of word registers. A mode register picks where the single data port goes. The data port can reach one of the four internal registers of the disk controller, or it can reach a local block-count register. Every controller register access therefore takes two bus operations: first a mode write that names the target, then the data-port access itself.

For DMA the block holds a 24-bit memory address, written as three byte registers, and a direction bit. It also holds a 16-byte FIFO between the controller's byte handshake and the memory port. When disk data comes in, bytes are accepted from the controller and written to memory in bursts of eight. When data goes out to the disk, memory is prefetched in bursts of eight and handed to the controller on request. The address advances by one for every byte moved on the memory side. The block count falls by one for every 512 bytes that enter the FIFO, and transfer stops when the count is zero. Changing the direction bit empties the FIFO. Software therefore clears it by writing the mode word with direction set and then with direction clear.

Top module: `fdma_bridge`

## Requirements
- R1: After reset the mode, the address and the block count are all zero. `mem_req` and `fc_dack` are low, and the status word reads 0.
- R2: Host register index 0 is the data port and index 1 is the mode/status register. With mode bit 4 clear, a data-port access drives `fc_cs` high in the same cycle, with `fc_we` following `hb_we`, `fc_wdata` equal to `hb_wdata[7:0]` and `fc_rs` equal to mode bits [2:1]. So mode 0x80, 0x82, 0x84 and 0x86 select controller registers 0, 1, 2 and 3. A data-port read returns `{8'h00, fc_rdata}`.
- R3: With mode bit 4 set, a data-port write loads `hb_wdata[7:0]` into the block count and leaves `fc_cs` low. A data-port read then returns the count in the low byte.
- R4: Host indices 2, 3 and 4 write the low, middle and high bytes of the DMA address from `hb_wdata[7:0]`. Reads of those indices return the current byte in bits [7:0], with zero above.
- R5: A mode write whose bit 8 differs from the stored direction empties the FIFO and restarts the count of bytes within the current block. A mode write with an unchanged bit 8 leaves the FIFO contents alone.
- R6: With direction clear (disk to memory), `fc_dack` equals `fc_drq` whenever the FIFO holds fewer than 16 bytes and the count is nonzero; the byte on `fc_din` is taken. Once 8 bytes are held, the block requests memory writes (`mem_req` high, `mem_we` high). It writes exactly 8 bytes, in arrival order, one per cycle with `mem_ack` high.
- R7: With direction set (memory to disk), the block requests 8 memory reads (`mem_we` low) whenever it holds 8 bytes or fewer and the count is nonzero. Each byte on `mem_rdata` is stored in the cycle `mem_ack` is high. `fc_dack` equals `fc_drq` while the FIFO is not empty, and `fc_dout` shows the oldest byte.
- R8: The count falls by one after each 512 bytes that enter the FIFO. While it is zero, no controller byte is accepted in the disk-to-memory direction, and no memory read burst starts in the memory-to-disk direction.
- R9: `mem_addr` shows the DMA address, which rises by one in the cycle after each acknowledged memory byte. The carry passes across all three bytes.
- R10: A read of host index 1 returns bit 0 set exactly when the block count is nonzero, and zero in all other bits.
- R11: The FIFO never accepts a byte while it holds 16 and never releases one while empty. With memory stalled, exactly 16 controller bytes are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hb_cs | input | 1 | Host access strobe, one cycle per access |
| hb_we | input | 1 | Host access is a write |
| hb_reg | input | 3 | Host register index |
| hb_wdata | input | 16 | Host write data |
| hb_rdata | output | 16 | Host read data, valid in the access cycle |
| fc_cs | output | 1 | Controller register access strobe |
| fc_we | output | 1 | Controller register access is a write |
| fc_rs | output | 2 | Controller register select |
| fc_wdata | output | 8 | Controller register write data |
| fc_rdata | input | 8 | Controller register read data |
| fc_drq | input | 1 | Controller offers (disk to memory) or wants (memory to disk) a byte |
| fc_dack | output | 1 | Byte handshake taken this cycle |
| fc_din | input | 8 | Byte from the controller |
| fc_dout | output | 8 | Byte to the controller |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory completes one byte this cycle |

## Verification
Controller strobes, host read data and `fc_dack` are combinational, so they are due in the same cycle as the stimulus. Register writes, address steps, count decrements and FIFO flushes take effect at the next rising edge. A memory burst request rises one cycle after the FIFO level crosses its threshold. The bench drives inputs just after the rising edge and compares every output at the falling edge. Its behavioural model is updated only after that comparison, so each check sees the state before the edge and the model's effect lands where the design's does.

// File: rtl/fdma_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the floppy DMA bridge.
// Assumes a 3-bit host register index; field positions of the mode word are
// fixed here because software and the register block both decode them.
package fdma_pkg;

    // host register indices
    localparam logic [2:0] REG_DATA   = 3'd0;
    localparam logic [2:0] REG_MODE   = 3'd1;
    localparam logic [2:0] REG_ADR_LO = 3'd2;

    // mode word field positions
    localparam int MODE_DIR_BIT  = 8;
    localparam int MODE_CSEL_BIT = 4;
    localparam int MODE_RS_LSB   = 1;

    typedef struct packed {
        logic       dir;      // 1: memory to disk
        logic       cnt_sel;  // 1: data port reaches block count
        logic [1:0] rs;       // controller register select
    } mode_t;

    typedef enum logic {
        BST_IDLE = 1'b0,
        BST_RUN  = 1'b1
    } bst_state_e;

endpackage

// File: rtl/fdma_fifo.sv
`timescale 1ns/1ps
// Byte FIFO with first-word fall-through output and synchronous flush.
// Assumes push is only acted on when not full and pop only when not empty;
// flush has priority over both.
module fdma_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push & ~full & ~flush;
    assign pop_ok  = pop & ~empty & ~flush;
    assign dout    = store[rd_ptr];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // data storage, written on an accepted push
    always_ff @(posedge clk) begin
        if (push_ok) store[wr_ptr] <= din;
    end

    // pointers and fill level
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= nxt(wr_ptr);
            if (pop_ok)  rd_ptr <= nxt(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/fdma_regs.sv
`timescale 1ns/1ps
// Host-visible state: mode word, DMA address, block count and the byte
// position inside the current block. Detects direction toggles as flushes.
// Assumes ADDR_W is a multiple of 8 and CNT_W is at most 8.
module fdma_regs
    import fdma_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int CNT_W     = 8,
    parameter int BLK_BYTES = 512,
    parameter int HB_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic [2:0]        host_reg,
    input  logic [HB_W-1:0]   host_wdata,
    input  logic              byte_in,
    input  logic              beat,
    output mode_t             mode_q,
    output logic              flush,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [CNT_W-1:0]  blk_cnt,
    output logic              cnt_nz
);
    localparam int NB   = ADDR_W / 8;
    localparam int BB_W = $clog2(BLK_BYTES);

    logic            host_wr, mode_wr, cnt_wr;
    logic [BB_W-1:0] blk_pos;

    assign host_wr = host_cs & host_we;
    assign mode_wr = host_wr & (host_reg == REG_MODE);
    assign cnt_wr  = host_wr & (host_reg == REG_DATA) & mode_q.cnt_sel;
    assign flush   = mode_wr & (host_wdata[MODE_DIR_BIT] != mode_q.dir);
    assign cnt_nz  = (blk_cnt != '0);

    // mode word capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_wr) begin
            mode_q.dir     <= host_wdata[MODE_DIR_BIT];
            mode_q.cnt_sel <= host_wdata[MODE_CSEL_BIT];
            mode_q.rs      <= host_wdata[MODE_RS_LSB +: 2];
        end
    end

    // DMA address: step per memory byte, host byte writes override
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_addr <= '0;
        end else begin
            if (beat) dma_addr <= dma_addr + 1'b1;
            for (int i = 0; i < NB; i++) begin
                if (host_wr && host_reg == 3'(int'(REG_ADR_LO) + i))
                    dma_addr[i*8 +: 8] <= host_wdata[7:0];
            end
        end
    end

    // block count and byte position within the block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_cnt <= '0;
            blk_pos <= '0;
        end else if (cnt_wr) begin
            blk_cnt <= host_wdata[CNT_W-1:0];
            blk_pos <= '0;
        end else if (flush) begin
            blk_pos <= '0;
        end else if (byte_in && cnt_nz) begin
            if (blk_pos == BB_W'(BLK_BYTES - 1)) begin
                blk_pos <= '0;
                blk_cnt <= blk_cnt - 1'b1;
            end else begin
                blk_pos <= blk_pos + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fdma_burst.sv
`timescale 1ns/1ps
// Memory burst sequencer. In the disk-to-memory direction it drains BURST
// bytes once that many are held; in the other direction it prefetches BURST
// bytes once that much room exists and blocks remain. One byte per mem_ack.
// Assumes BURST >= 2 and BURST divides the block size.
module fdma_burst
    import fdma_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BURST = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       dir,
    input  logic [$clog2(DEPTH+1)-1:0] level,
    input  logic                       cnt_nz,
    input  logic                       flush,
    input  logic                       mem_ack,
    output logic                       mem_req,
    output logic                       beat
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam int BW = $clog2(BURST);

    bst_state_e    state;
    logic [BW-1:0] beats;
    logic          start;

    assign start   = dir ? ((level <= LW'(DEPTH - BURST)) && cnt_nz)
                         : (level >= LW'(BURST));
    assign mem_req = (state == BST_RUN);
    assign beat    = mem_req & mem_ack & ~flush;

    // burst state and beat counter
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            state <= BST_IDLE;
            beats <= '0;
        end else begin
            case (state)
                BST_IDLE: begin
                    beats <= '0;
                    if (start) state <= BST_RUN;
                end
                BST_RUN: begin
                    if (beat) begin
                        if (beats == BW'(BURST - 1)) begin
                            state <= BST_IDLE;
                            beats <= '0;
                        end else begin
                            beats <= beats + 1'b1;
                        end
                    end
                end
                default: state <= BST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fdma_bridge.sv
`timescale 1ns/1ps
// Floppy DMA bridge: host register window, controller register routing,
// controller byte handshake, FIFO and memory burst port.
// Assumes host accesses last one cycle and mem_ack only comes with mem_req.
module fdma_bridge
    import fdma_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int CNT_W      = 8,
    parameter int BLK_BYTES  = 512,
    parameter int FIFO_DEPTH = 16,
    parameter int HB_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hb_cs,
    input  logic              hb_we,
    input  logic [2:0]        hb_reg,
    input  logic [HB_W-1:0]   hb_wdata,
    output logic [HB_W-1:0]   hb_rdata,
    output logic              fc_cs,
    output logic              fc_we,
    output logic [1:0]        fc_rs,
    output logic [7:0]        fc_wdata,
    input  logic [7:0]        fc_rdata,
    input  logic              fc_drq,
    output logic              fc_dack,
    input  logic [7:0]        fc_din,
    output logic [7:0]        fc_dout,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack
);
    localparam int BURST = FIFO_DEPTH / 2;
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
    localparam int NB    = ADDR_W / 8;

    mode_t             mode_q;
    logic              flush, cnt_nz, beat, rd_mode;
    logic [ADDR_W-1:0] dma_addr;
    logic [CNT_W-1:0]  blk_cnt;
    logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
    logic [7:0]        fifo_din, fifo_dout;
    logic [LVL_W-1:0]  fifo_level;

    fdma_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BLK_BYTES(BLK_BYTES), .HB_W(HB_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_cs(hb_cs), .host_we(hb_we), .host_reg(hb_reg), .host_wdata(hb_wdata),
        .byte_in(fifo_push), .beat(beat),
        .mode_q(mode_q), .flush(flush), .dma_addr(dma_addr),
        .blk_cnt(blk_cnt), .cnt_nz(cnt_nz)
    );

    fdma_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(fifo_push), .din(fifo_din), .pop(fifo_pop),
        .dout(fifo_dout), .level(fifo_level), .full(fifo_full), .empty(fifo_empty)
    );

    fdma_burst #(.DEPTH(FIFO_DEPTH), .BURST(BURST)) u_burst (
        .clk(clk), .rst_n(rst_n), .dir(mode_q.dir), .level(fifo_level),
        .cnt_nz(cnt_nz), .flush(flush), .mem_ack(mem_ack),
        .mem_req(mem_req), .beat(beat)
    );

    // datapath steering by direction
    always_comb begin
        rd_mode   = ~mode_q.dir;
        fc_dack   = fc_drq & ~flush & (mode_q.dir ? ~fifo_empty : (~fifo_full & cnt_nz));
        fifo_push = rd_mode ? fc_dack : beat;
        fifo_din  = rd_mode ? fc_din  : mem_rdata;
        fifo_pop  = rd_mode ? beat    : fc_dack;
    end

    assign fc_dout   = fifo_dout;
    assign mem_wdata = fifo_dout;
    assign mem_addr  = dma_addr;
    assign mem_we    = mem_req & ~mode_q.dir;

    // controller register routing from the data port
    assign fc_cs    = hb_cs & (hb_reg == REG_DATA) & ~mode_q.cnt_sel;
    assign fc_we    = hb_we;
    assign fc_rs    = mode_q.rs;
    assign fc_wdata = hb_wdata[7:0];

    // host read multiplexer
    always_comb begin
        hb_rdata = '0;
        if (hb_reg == REG_DATA) begin
            hb_rdata[7:0] = mode_q.cnt_sel ? 8'(blk_cnt) : fc_rdata;
        end else if (hb_reg == REG_MODE) begin
            hb_rdata[0] = cnt_nz;
        end
        for (int i = 0; i < NB; i++) begin
            if (hb_reg == 3'(int'(REG_ADR_LO) + i)) hb_rdata[7:0] = dma_addr[i*8 +: 8];
        end
    end

endmodule

// File: rtl/fdma_checker.sv
`timescale 1ns/1ps
// Property checker for fdma_bridge, attached by bind. Observes ports and a
// few internal nets; drives nothing.
module fdma_checker
    import fdma_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 8,
    parameter int LW     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hb_cs,
    input logic              hb_we,
    input logic [2:0]        hb_reg,
    input logic              status0,
    input logic              fc_cs,
    input logic              fc_dack,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mode_dir,
    input logic              cnt_sel,
    input logic              flush,
    input logic [CNT_W-1:0]  blk_cnt,
    input logic [LW-1:0]     fifo_level,
    input logic              fifo_pop
);
    logic addr_wr;
    assign addr_wr = hb_cs & hb_we & (hb_reg >= REG_ADR_LO) & (hb_reg <= REG_ADR_LO + 3'd2);

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LW'(DEPTH));

    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop && !flush |-> fifo_level != '0);

    assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && !addr_wr && !flush |=> mem_addr == $past(mem_addr) + 1'b1);

    assert_stop_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_dir && blk_cnt == '0 |-> !fc_dack);

    assert_count_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hb_cs && hb_reg == REG_DATA && cnt_sel |-> !fc_cs);

    assert_flush_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> fifo_level == '0);

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !flush |=> mem_req);

    assert_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_we == !mode_dir);

    assert_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hb_cs && !hb_we && hb_reg == REG_MODE |-> status0 == (blk_cnt != '0));

endmodule

bind fdma_bridge fdma_checker #(
    .DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LW(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hb_cs(hb_cs), .hb_we(hb_we), .hb_reg(hb_reg),
    .status0(hb_rdata[0]), .fc_cs(fc_cs), .fc_dack(fc_dack),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr),
    .mode_dir(mode_q.dir), .cnt_sel(mode_q.cnt_sel), .flush(flush),
    .blk_cnt(blk_cnt), .fifo_level(fifo_level), .fifo_pop(fifo_pop)
);

// File: tb/sim_fdma_bridge.sv
`timescale 1ns/1ps
// Bench for fdma_bridge: behavioural queue model compared at every falling edge.
module sim_fdma_bridge;
    localparam int DEPTH = 16;
    localparam int BLK   = 512;

    logic        clk = 0, rst_n = 0;
    logic        hb_cs = 0, hb_we = 0;
    logic [2:0]  hb_reg = 0;
    logic [15:0] hb_wdata = 0, hb_rdata;
    logic        fc_cs, fc_we, fc_dack;
    logic [1:0]  fc_rs;
    logic [7:0]  fc_wdata, fc_dout, mem_wdata;
    logic [7:0]  fc_rdata = 0, fc_din = 0, mem_rdata = 0;
    logic        fc_drq = 0, mem_ack = 0, mem_req, mem_we;
    logic [23:0] mem_addr;

    fdma_bridge u0 (
        .clk(clk), .rst_n(rst_n), .hb_cs(hb_cs), .hb_we(hb_we), .hb_reg(hb_reg),
        .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .fc_cs(fc_cs), .fc_we(fc_we),
        .fc_rs(fc_rs), .fc_wdata(fc_wdata), .fc_rdata(fc_rdata), .fc_drq(fc_drq),
        .fc_dack(fc_dack), .fc_din(fc_din), .fc_dout(fc_dout), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    always #5 clk = ~clk;

    int nvec = 0, nfail = 0, cyc = 0, n_in = 0, n_out = 0;
    bit mon_on = 0, mem_en = 0;

    // reference model state
    bit          m_dir = 0, m_sel = 0;
    logic [23:0] m_addr = 0;
    int          m_cnt = 0, m_bb = 0;
    logic [7:0]  m_q[$];
    logic        exp_dack, do_push;
    logic [7:0]  pin;
    string       tag;

    // last controller strobe seen during a host access
    logic        l_cs, l_we;
    logic [1:0]  l_rs;
    logic [7:0]  l_wd;

    function automatic logic [7:0] mfun(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", t, act, exp, cyc);
        end
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                nfail++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
                $finish;
            end
        end
    end

    // memory responder: acks three cycles of four, data from the address
    initial begin
        forever begin
            @(posedge clk);
            #1;
            mem_ack   = mem_en && mem_req && (cyc % 4 != 3);
            mem_rdata = mfun(mem_addr);
        end
    end

    // compare outputs against the model, then advance the model
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            exp_dack = m_dir ? (fc_drq && m_q.size() > 0)
                             : (fc_drq && m_q.size() < DEPTH && m_cnt != 0);
            if (!m_dir && m_cnt == 0)                   tag = "R8";
            else if (m_q.size() == 0 || m_q.size() == DEPTH) tag = "R11";
            else                                        tag = m_dir ? "R7" : "R6";
            chk(fc_dack === exp_dack, tag, 32'(fc_dack), 32'(exp_dack));
            do_push = 0;
            if (fc_dack && exp_dack) begin
                if (m_dir) begin
                    if (m_q.size() > 0) begin
                        chk(fc_dout === m_q[0], "R7", 32'(fc_dout), 32'(m_q[0]));
                        void'(m_q.pop_front());
                    end
                    n_out++;
                end else begin
                    do_push = 1;
                    pin = fc_din;
                    n_in++;
                end
            end
            if (mem_req) begin
                chk(mem_addr === m_addr, "R9", 32'(mem_addr), 32'(m_addr));
                chk(mem_we === !m_dir, "R6", 32'(mem_we), 32'(!m_dir));
            end
            if (mem_req && mem_ack) begin
                if (!m_dir) begin
                    if (m_q.size() > 0) begin
                        chk(mem_wdata === m_q[0], "R6", 32'(mem_wdata), 32'(m_q[0]));
                        void'(m_q.pop_front());
                    end else begin
                        chk(0, "R11", 32'(m_q.size()), 32'd1);
                    end
                end else begin
                    do_push = 1;
                    pin = mfun(m_addr);
                end
                m_addr = m_addr + 1;
            end
            if (do_push) begin
                m_q.push_back(pin);
                if (m_bb == BLK - 1) begin
                    m_bb = 0;
                    m_cnt--;
                end else begin
                    m_bb++;
                end
            end
            if (hb_cs && hb_we) begin
                case (hb_reg)
                    3'd0: if (m_sel) begin m_cnt = int'(hb_wdata[7:0]); m_bb = 0; end
                    3'd1: begin
                        if (hb_wdata[8] != m_dir) begin m_q.delete(); m_bb = 0; end
                        m_dir = hb_wdata[8];
                        m_sel = hb_wdata[4];
                    end
                    3'd2: m_addr[7:0]   = hb_wdata[7:0];
                    3'd3: m_addr[15:8]  = hb_wdata[7:0];
                    3'd4: m_addr[23:16] = hb_wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic host_wr(input logic [2:0] r, input logic [15:0] d);
        @(posedge clk); #1;
        hb_cs = 1; hb_we = 1; hb_reg = r; hb_wdata = d;
        @(negedge clk);
        l_cs = fc_cs; l_we = fc_we; l_rs = fc_rs; l_wd = fc_wdata;
        @(posedge clk); #1;
        hb_cs = 0; hb_we = 0;
    endtask

    task automatic host_rd(input logic [2:0] r, output logic [15:0] d);
        @(posedge clk); #1;
        hb_cs = 1; hb_we = 0; hb_reg = r;
        @(negedge clk);
        d = hb_rdata;
        l_cs = fc_cs; l_we = fc_we; l_rs = fc_rs;
        @(posedge clk); #1;
        hb_cs = 0;
    endtask

    // drive the controller byte handshake for n cycles
    task automatic drive_drq(input int n, input bit steady);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            fc_drq = steady ? 1'b1 : (k % 5 != 4);
            fc_din = 8'(k * 7 + 3);
        end
        @(posedge clk); #1;
        fc_drq = 0;
    endtask

    logic [15:0] rd;
    int base;

    initial begin
        // R1: reset state
        fc_drq = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_req === 1'b0, "R1", 32'(mem_req), 0);
        chk(fc_dack === 1'b0, "R1", 32'(fc_dack), 0);
        @(posedge clk); #1;
        fc_drq = 0; rst_n = 1;
        mon_on = 1;
        host_rd(3'd1, rd); chk(rd === 16'h0000, "R1", 32'(rd), 0);
        for (int i = 2; i <= 4; i++) begin
            host_rd(3'(i), rd); chk(rd === 16'h0000, "R1", 32'(rd), 0);
        end

        // R4: address bytes, upper host bits dropped
        host_wr(3'd2, 16'hABF0);
        host_wr(3'd3, 16'h55FF);
        host_wr(3'd4, 16'h0012);
        host_rd(3'd2, rd); chk(rd === 16'h00F0, "R4", 32'(rd), 32'h00F0);
        host_rd(3'd3, rd); chk(rd === 16'h00FF, "R4", 32'(rd), 32'h00FF);
        host_rd(3'd4, rd); chk(rd === 16'h0012, "R4", 32'(rd), 32'h0012);

        // R2: controller register routing for every select
        for (int s = 0; s < 4; s++) begin
            host_wr(3'd1, 16'h0080 | 16'(s << 1));
            host_wr(3'd0, 16'hE740 + 16'(s));
            chk(l_cs === 1'b1 && l_we === 1'b1, "R2", {30'd0, l_cs, l_we}, 3);
            chk(l_rs === 2'(s), "R2", 32'(l_rs), 32'(s));
            chk(l_wd === 8'h40 + 8'(s), "R2", 32'(l_wd), 32'h40 + s);
            fc_rdata = 8'hC0 + 8'(s);
            host_rd(3'd0, rd);
            chk(rd === 16'h00C0 + 16'(s), "R2", 32'(rd), 32'hC0 + s);
            chk(l_cs === 1'b1 && l_we === 1'b0, "R2", {30'd0, l_cs, l_we}, 2);
        end

        // R3 / R5: flush sequence, then load the count through the data port
        host_wr(3'd1, 16'h0190);
        host_wr(3'd1, 16'h0090);
        host_wr(3'd0, 16'h0002);
        chk(l_cs === 1'b0, "R3", 32'(l_cs), 0);
        host_rd(3'd0, rd); chk(rd === 16'h0002, "R3", 32'(rd), 2);
        host_rd(3'd1, rd); chk(rd === 16'h0001, "R10", 32'(rd), 1);

        // R6/R8/R9: disk to memory, two blocks from 0x12FFF0
        mem_en = 1;
        for (int k = 0; k < 8000 && !(n_in == 1024 && m_q.size() == 0); k++) begin
            @(posedge clk); #1;
            fc_drq = (k % 5 != 4);
            fc_din = 8'(k * 13 + 1);
        end
        @(posedge clk); #1; fc_drq = 0;
        repeat (4) @(posedge clk);
        mem_en = 0;
        chk(n_in == 1024, "R8", 32'(n_in), 1024);
        host_rd(3'd1, rd); chk(rd === 16'h0000, "R10", 32'(rd), 0);
        host_rd(3'd0, rd); chk(rd === 16'h0000, "R8", 32'(rd), 0);
        host_rd(3'd2, rd); chk(rd === 16'h00F0, "R9", 32'(rd), 32'hF0);
        host_rd(3'd3, rd); chk(rd === 16'h0003, "R9", 32'(rd), 3);
        host_rd(3'd4, rd); chk(rd === 16'h0013, "R9", 32'(rd), 32'h13);
        drive_drq(20, 1);   // R8: refused at zero count
        chk(n_in == 1024, "R8", 32'(n_in), 1024);

        // R7/R8: memory to disk, one block from 0x000100
        host_wr(3'd1, 16'h0190);
        host_wr(3'd2, 16'h0000);
        host_wr(3'd3, 16'h0001);
        host_wr(3'd4, 16'h0000);
        host_wr(3'd0, 16'h0001);
        mem_en = 1;
        for (int k = 0; k < 8000 && n_out < 512; k++) begin
            @(posedge clk); #1;
            fc_drq = (k % 3 != 1);
        end
        @(posedge clk); #1; fc_drq = 0;
        chk(n_out == 512, "R7", 32'(n_out), 512);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            chk(mem_req === 1'b0, "R8", 32'(mem_req), 0);
        end
        mem_en = 0;
        host_rd(3'd2, rd); chk(rd === 16'h0000, "R9", 32'(rd), 0);
        host_rd(3'd3, rd); chk(rd === 16'h0003, "R9", 32'(rd), 3);

        // R5: same-direction mode write keeps data; toggle discards it
        host_wr(3'd0, 16'h0001);
        mem_en = 1;
        repeat (40) @(posedge clk);
        mem_en = 0;
        chk(m_q.size() == 16, "R11", 32'(m_q.size()), 16);
        host_wr(3'd1, 16'h0184);
        base = n_out;
        drive_drq(4, 1);
        chk(n_out - base == 4, "R5", 32'(n_out - base), 4);
        host_wr(3'd1, 16'h0090);
        base = n_in;
        drive_drq(25, 1);
        chk(n_in - base == 16, "R11", 32'(n_in - base), 16);
        mem_en = 1;
        repeat (40) @(posedge clk);
        mem_en = 0;
        chk(m_q.size() == 0, "R6", 32'(m_q.size()), 0);
        host_rd(3'd2, rd); chk(rd === 16'h0020, "R5", 32'(rd), 32'h20);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule